// File: doc/BRIEF.md
# Timer Compare Unit with Event Trigger

This block pairs a 16-bit synchronous up-counter with two compare channels. Each channel holds a compare value and a 4-bit mode. When the counter is about to advance and its value equals a channel's compare value, the channel acts according to its mode. It can drive its own output pin high or low. It can raise only its interrupt flag. It can fire an event trigger that returns the counter to zero, so its compare value sets the timer period. The trigger of the second channel also issues a one-cycle start strobe to an external converter, gated by an enable input.

Software programs the unit through a plain register write port. A write is accepted in the cycle that `wr_en` is high, so there is no back-pressure. The pins, the flags and the converter strobe are plain level or pulse outputs with no handshake. The counter value is visible on its own output bus. The counter only advances on clock cycles where the run bit is set and `tick_en` is high, so every part of the unit stays synchronous to `clk`.

Top module: `tcmp_top`

## Requirements
- R1: With channel 0 in mode 1011 (event), a match returns the counter to 0 on the next edge instead of incrementing, so the count cycles through 0..C (period C+1 advances, where C is the compare value).
- R2: With channel 1 in mode 1011, a match clears the counter as in R1. When `adc_en` is high in the match cycle, `adc_start` is high for the cycle after the match edge. When `adc_en` is low, no strobe is issued.
- R3: A counter clear caused by an event trigger never sets `ovf_flag`, even when the clear happens at count 0xFFFF.
- R4: In mode 1010 (flag only), a match sets the channel flag and the channel pin keeps its level. Writing 1010 does not change the pin.
- R5: Writing mode 0000 to a channel forces its pin low on the next edge.
- R6: Writing mode 1000 drives the pin low, and the first match drives it high. Writing mode 1001 drives the pin high, and the first match drives it low. The level then holds through later matches until the mode is rewritten.
- R7: While the run bit is 1 and `tick_en` is 1, the counter increments once per clock. With either one low, it holds. Wrapping from 0xFFFF to 0 sets `ovf_flag`.
- R8: A match is a cycle in which the counter advances, the mode is active and the count equals the compare value. A match sets the channel flag on the next edge. Flags stay set until a write to address 2 with a 1 in the flag's bit: bit 0 is `ovf_flag`, bit 1 is channel 0, bit 2 is channel 1. Zero bits leave a flag unchanged, and a set in the same cycle wins over a clear.
- R9: Mode codes other than 0000, 1000, 1001, 1010 and 1011 act as off: there is no flag, no pin change and no counter clear.
- R10: `adc_start` is a single-cycle pulse for each qualifying match.
- R11: After reset the counter, the run bit, all modes, all flags, the pins and `adc_start` are zero.
- R12: The register addresses are: 0 is control (bit 0 = run); 1 loads the counter; 2 clears flags; 3 and 4 are channel 0's compare value and mode (mode in data bits 3:0); 5 and 6 are the same for channel 1. A counter load takes priority over counting and suppresses matches in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable qualifier |
| adc_en | input | 1 | Allows the converter strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| tmr_count | output | 16 | Current counter value |
| ovf_flag | output | 1 | Counter wrap flag |
| cmp_flag | output | 2 | Per-channel match flags |
| cmp_pin | output | 2 | Per-channel compare output latches |
| adc_start | output | 1 | Converter start strobe |

## Verification
The counter is first run with no channel active, so the bench can check plain increments, holds when the run bit or `tick_en` is low, and the wrap that sets the overflow flag. It then runs with an event-mode compare at 4 and at 0xFFFF. Together these separate a trigger clear from a natural wrap, and show whether the clear leaks into the overflow flag. Channel 1 is run in event mode with the converter enable high and then low, counting strobes to tell gated from ungated pulses and to detect stretched pulses. The pin modes are tried in sequences that separate the level set when the mode is written from the level set on a match, and these are contrasted with the flag-only and undefined codes.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
  typedef enum logic [3:0] {
    MODE_OFF    = 4'b0000,
    MODE_SET_HI = 4'b1000,
    MODE_SET_LO = 4'b1001,
    MODE_FLAG   = 4'b1010,
    MODE_EVENT  = 4'b1011
  } tcmp_mode_e;

  localparam int ADDR_CTRL    = 0;
  localparam int ADDR_TMR     = 1;
  localparam int ADDR_FLAGCLR = 2;

  function automatic int cmp_addr(input int ch);
    return 3 + 2 * ch;
  endfunction

  function automatic int mode_addr(input int ch);
    return 4 + 2 * ch;
  endfunction

  function automatic logic mode_active(input logic [3:0] m);
    return (m == MODE_SET_HI) || (m == MODE_SET_LO) ||
           (m == MODE_FLAG) || (m == MODE_EVENT);
  endfunction
endpackage

// File: rtl/tcmp_timer.sv
module tcmp_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          evt_clr,
  input  logic          ovf_clr,
  output logic [TW-1:0] cnt,
  output logic          ovf
);
  localparam logic [TW-1:0] CNT_MAX = '1;

  logic wrap;
  assign wrap = adv && !evt_clr && (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (adv) begin
      if (evt_clr) cnt <= '0;
      else         cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ovf <= 1'b0;
    else if (wrap)    ovf <= 1'b1;
    else if (ovf_clr) ovf <= 1'b0;
  end
endmodule

// File: rtl/tcmp_chan.sv
module tcmp_chan
  import tcmp_pkg::*;
#(
  parameter int TW = 16,
  parameter int MW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] cnt,
  input  logic          adv,
  input  logic          wr_cmp,
  input  logic          wr_mode,
  input  logic [TW-1:0] wdata,
  input  logic          flag_clr,
  output logic          pin,
  output logic          flag,
  output logic          hit,
  output logic          evt,
  output logic [MW-1:0] mode_o
);
  logic [TW-1:0] cmp_q;
  logic [MW-1:0] mode_q;

  assign hit    = adv && mode_active(mode_q) && (cnt == cmp_q);
  assign evt    = hit && (mode_q == MODE_EVENT);
  assign mode_o = mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      mode_q <= '0;
    end else begin
      if (wr_cmp)  cmp_q  <= wdata;
      if (wr_mode) mode_q <= wdata[MW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin <= 1'b0;
    end else if (wr_mode) begin
      case (wdata[MW-1:0])
        MODE_OFF:    pin <= 1'b0;
        MODE_SET_HI: pin <= 1'b0;
        MODE_SET_LO: pin <= 1'b1;
        default:     pin <= pin;
      endcase
    end else if (hit) begin
      if (mode_q == MODE_SET_HI)      pin <= 1'b1;
      else if (mode_q == MODE_SET_LO) pin <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        flag <= 1'b0;
    else if (hit)      flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end
endmodule

// File: rtl/tcmp_top.sv
module tcmp_top
  import tcmp_pkg::*;
#(
  parameter int TW     = 16,
  parameter int NCH    = 2,
  parameter int ADC_CH = 1,
  parameter int AW     = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_en,
  input  logic           adc_en,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [TW-1:0]  wr_data,
  output logic [TW-1:0]  tmr_count,
  output logic           ovf_flag,
  output logic [NCH-1:0] cmp_flag,
  output logic [NCH-1:0] cmp_pin,
  output logic           adc_start
);
  localparam int MW = 4;

  logic           run_q;
  logic           ld_tmr;
  logic           flag_wr;
  logic           tick_go;
  logic           evt_any;
  logic [NCH-1:0] hit;
  logic [NCH-1:0] evt;
  logic [NCH-1:0] mode_wr;
  logic [NCH-1:0] cmp_wr;
  logic [NCH*MW-1:0] mode_flat;

  assign ld_tmr  = wr_en && (wr_addr == AW'(ADDR_TMR));
  assign flag_wr = wr_en && (wr_addr == AW'(ADDR_FLAGCLR));
  assign tick_go = run_q && tick_en && !ld_tmr;
  assign evt_any = |evt;

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= 1'b0;
    else if (wr_en && (wr_addr == AW'(ADDR_CTRL))) run_q <= wr_data[0];
  end

  tcmp_timer #(.TW(TW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (tick_go),
    .load     (ld_tmr),
    .load_val (wr_data),
    .evt_clr  (evt_any),
    .ovf_clr  (flag_wr && wr_data[0]),
    .cnt      (tmr_count),
    .ovf      (ovf_flag)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign cmp_wr[g]  = wr_en && (wr_addr == AW'(cmp_addr(g)));
    assign mode_wr[g] = wr_en && (wr_addr == AW'(mode_addr(g)));

    tcmp_chan #(.TW(TW), .MW(MW)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt      (tmr_count),
      .adv      (tick_go),
      .wr_cmp   (cmp_wr[g]),
      .wr_mode  (mode_wr[g]),
      .wdata    (wr_data),
      .flag_clr (flag_wr && wr_data[g+1]),
      .pin      (cmp_pin[g]),
      .flag     (cmp_flag[g]),
      .hit      (hit[g]),
      .evt      (evt[g]),
      .mode_o   (mode_flat[g*MW +: MW])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) adc_start <= 1'b0;
    else        adc_start <= evt[ADC_CH] && adc_en;
  end
endmodule

// File: rtl/tcmp_chk.sv
module tcmp_chk #(
  parameter int TW     = 16,
  parameter int NCH    = 2,
  parameter int ADC_CH = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_go,
  input logic              evt_any,
  input logic [NCH-1:0]    evt,
  input logic [NCH-1:0]    hit,
  input logic [NCH-1:0]    mode_wr,
  input logic [NCH*4-1:0]  mode_flat,
  input logic [3:0]        wdata_lo,
  input logic              adc_en,
  input logic              adc_start,
  input logic [TW-1:0]     cnt,
  input logic              ovf_flag,
  input logic [NCH-1:0]    flag,
  input logic [NCH-1:0]    pin
);
  localparam logic [TW-1:0] CNT_MAX = '1;

  p_event_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    evt_any |=> (cnt == '0));

  p_adc_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> $past(evt[ADC_CH] && adc_en));

  p_adc_fires_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt[ADC_CH] && adc_en) |=> adc_start);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_any && !ovf_flag) |=> !ovf_flag);

  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_go && !evt_any && cnt == CNT_MAX) |=> (ovf_flag && cnt == '0));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    p_flag_pin_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_flat[g*4 +: 4] == 4'b1010 && !mode_wr[g]) |=> $stable(pin[g]));

    p_zero_mode_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr[g] && wdata_lo == 4'b0000) |=> !pin[g]);

    p_flag_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hit[g] |=> flag[g]);
  end
endmodule

bind tcmp_top tcmp_chk #(.TW(TW), .NCH(NCH), .ADC_CH(ADC_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_go   (tick_go),
  .evt_any   (evt_any),
  .evt       (evt),
  .hit       (hit),
  .mode_wr   (mode_wr),
  .mode_flat (mode_flat),
  .wdata_lo  (wr_data[3:0]),
  .adc_en    (adc_en),
  .adc_start (adc_start),
  .cnt       (tmr_count),
  .ovf_flag  (ovf_flag),
  .flag      (cmp_flag),
  .pin       (cmp_pin)
);

// File: tb/sim_tcmp_top.sv
module sim_tcmp_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b1;
  logic        adc_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] tmr_count;
  logic        ovf_flag;
  logic [1:0]  cmp_flag;
  logic [1:0]  cmp_pin;
  logic        adc_start;

  int vectors = 0;
  int errs = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcmp_top u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .adc_en(adc_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tmr_count(tmr_count), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag),
    .cmp_pin(cmp_pin), .adc_start(adc_start)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errs = errs + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int addr, input logic [15:0] data);
    wr_en = 1'b1;
    wr_addr = 3'(addr);
    wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic quiesce();
    wr(0, 16'h0);
    wr(4, 16'h0);
    wr(6, 16'h0);
    wr(2, 16'h7);
    wr(1, 16'h0);
  endtask

  task automatic t_reset();
    chk("R11 count", tmr_count, 0);
    chk("R11 ovf", ovf_flag, 0);
    chk("R11 flags", cmp_flag, 0);
    chk("R11 pins", cmp_pin, 0);
    chk("R11 adc", adc_start, 0);
    idle(3);
    chk("R11 run bit clear, no counting", tmr_count, 0);
  endtask

  task automatic t_count();
    quiesce();
    wr(1, 16'd5);
    wr(0, 16'h1);
    idle(3);
    chk("R7 increments", tmr_count, 8);
    tick_en = 1'b0;
    idle(4);
    chk("R7 hold tick_en low", tmr_count, 8);
    tick_en = 1'b1;
    idle(1);
    chk("R7 resume", tmr_count, 9);
    wr(1, 16'hFFFE);
    chk("R12 load wins", tmr_count, 16'hFFFE);
    idle(2);
    chk("R7 wrap count", tmr_count, 0);
    chk("R7 wrap ovf", ovf_flag, 1);
  endtask

  task automatic t_period();
    quiesce();
    wr(3, 16'd4);
    wr(4, 16'hB);
    wr(0, 16'h1);
    idle(7);
    chk("R1 period count", tmr_count, 2);
    chk("R1 flag", cmp_flag[0], 1);
    idle(5);
    chk("R1 period repeat", tmr_count, 2);
    chk("R3 ovf untouched", ovf_flag, 0);
  endtask

  task automatic t_event_at_max();
    quiesce();
    wr(3, 16'hFFFF);
    wr(4, 16'hB);
    wr(0, 16'h1);
    wr(1, 16'hFFFE);
    idle(2);
    chk("R3 clear at max count", tmr_count, 0);
    chk("R3 no ovf", ovf_flag, 0);
    chk("R3 flag", cmp_flag[0], 1);
  endtask

  task automatic t_adc(input logic en, input int exp_pulses, input string tag);
    int pulses = 0;
    int dbl = 0;
    logic prev = 1'b0;
    quiesce();
    adc_en = en;
    wr(5, 16'd3);
    wr(6, 16'hB);
    wr(0, 16'h1);
    for (int i = 0; i < 12; i++) begin
      idle(1);
      if (adc_start) pulses++;
      if (adc_start && prev) dbl++;
      prev = adc_start;
    end
    chk({tag, " pulses"}, pulses, exp_pulses);
    chk("R10 single-cycle strobe", dbl, 0);
    chk("R2 timer cleared", tmr_count, 0);
    chk("R2 flag", cmp_flag[1], 1);
    adc_en = 1'b0;
  endtask

  task automatic t_flag_only();
    quiesce();
    wr(3, 16'd2);
    wr(4, 16'h9);
    chk("R6 set-low preset high", cmp_pin[0], 1);
    wr(4, 16'hA);
    chk("R4 write keeps pin", cmp_pin[0], 1);
    wr(0, 16'h1);
    idle(4);
    chk("R4 flag set", cmp_flag[0], 1);
    chk("R4 pin unchanged", cmp_pin[0], 1);
    chk("R4 no clear", tmr_count, 4);
    wr(0, 16'h0);
    wr(4, 16'h0);
    chk("R5 zero mode low", cmp_pin[0], 0);
  endtask

  task automatic t_pin_modes();
    quiesce();
    wr(3, 16'd2);
    wr(4, 16'h9);
    wr(4, 16'h8);
    chk("R6 set-high preset low", cmp_pin[0], 0);
    wr(0, 16'h1);
    idle(1);
    chk("R6 before match", cmp_pin[0], 0);
    idle(2);
    chk("R6 high after match", cmp_pin[0], 1);
    idle(5);
    chk("R6 holds", cmp_pin[0], 1);
    wr(0, 16'h0);
    wr(4, 16'h9);
    chk("R6 set-low preset", cmp_pin[0], 1);
    wr(1, 16'h0);
    wr(0, 16'h1);
    idle(4);
    chk("R6 low after match", cmp_pin[0], 0);
  endtask

  task automatic t_flags();
    wr(0, 16'h0);
    chk("R8 flag pending", cmp_flag[0], 1);
    wr(2, 16'h0);
    chk("R8 zero write keeps", cmp_flag[0], 1);
    wr(2, 16'h4);
    chk("R8 other bit keeps", cmp_flag[0], 1);
    wr(2, 16'h2);
    chk("R8 bit1 clears", cmp_flag[0], 0);
  endtask

  task automatic t_invalid();
    quiesce();
    wr(3, 16'd2);
    wr(4, 16'h9);
    wr(4, 16'hC);
    chk("R9 write keeps pin", cmp_pin[0], 1);
    wr(0, 16'h1);
    idle(6);
    chk("R9 no clear", tmr_count, 6);
    chk("R9 no flag", cmp_flag[0], 0);
    chk("R9 pin unchanged", cmp_pin[0], 1);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_count();
    t_period();
    t_event_at_max();
    t_adc(1'b1, 3, "R2 enabled");
    t_adc(1'b0, 0, "R2 disabled");
    t_flag_only();
    t_pin_modes();
    t_flags();
    t_invalid();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule